// File: doc/BRIEF.md
# Dispatch Group Slot Hazard Checker

This block models how a superscalar front end packs instructions into dispatch groups of a fixed number of slots. For each candidate instruction, presented as a bundle of attributes (execution unit class, first-only, single, cracked, count-register write, branch through count register, pseudo), it reports at once whether the instruction can join the group being formed. The answer is one of three classes: no hazard, hazard (the instruction must wait for a fresh group), or no-op hazard (a no-op must be padded in before the instruction).

The state is a slot counter and a flag that records a count-register write earlier in the same group. An issue strobe commits the presented instruction and updates that state. An advance strobe spends one empty slot. A branch or a single-flagged instruction closes the group when it issues. When the counter reaches the last slot, the group ends and all state returns to an empty group.

Top module: `dgrp_hazard_top`

## Requirements
- R1: After synchronous reset the group is empty: slotsUsed is 0 and a plain fixed-point candidate returns class 2'b00 (none).
- R2: The hazard output encodes 2'b00 as none, 2'b01 as hazard and 2'b10 as no-op hazard. It is combinational from the current state and the presented attributes.
- R3: A non-branch unit instruction (unitClass 0 fixed-point, 1 load/store, 2 float, 3 vector ALU, 4 vector permute) returns hazard when four slots are used. A branch (unitClass 6) returns none in that case.
- R4: An instruction flagged first-only or single returns hazard whenever slotsUsed is not 0.
- R5: A cracked instruction returns hazard when more than two slots are used. When it issues it consumes two slots.
- R6: A condition-register unit instruction (unitClass 5) returns hazard when two or more slots are used.
- R7: Issuing a branch or a single-flagged instruction closes the group, and slotsUsed returns to 0 on the next cycle.
- R8: After a count-register write has issued in the current group, a branch through the count register returns no-op hazard. If a plain hazard rule also applies, hazard takes precedence. The flag clears when the group ends.
- R9: A pseudo instruction always returns none, and issuing it leaves slotsUsed unchanged.
- R10: An advance consumes one slot. When slotsUsed reaches 5 the group ends and slotsUsed becomes 0.
- R11: State changes only on an issue or advance strobe at a rising clock edge. A check with neither strobe leaves slotsUsed unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| unitClass | input | 3 | Unit class of candidate (0..6) |
| isFirst | input | 1 | Candidate must lead a group |
| isSingle | input | 1 | Candidate fills a whole group |
| isCracked | input | 1 | Candidate takes two slots |
| isCtrWrite | input | 1 | Candidate writes the count register |
| isCtrBranch | input | 1 | Candidate branches through the count register |
| isPseudo | input | 1 | Candidate is a pseudo instruction |
| issueStb | input | 1 | Commit candidate this cycle |
| advanceStb | input | 1 | Spend one empty slot this cycle |
| hazard | output | 2 | Hazard class for candidate |
| slotsUsed | output | 3 | Slots used in current group |

## Verification
The hazard class is combinational, so the bench samples it in the same cycle the attributes are driven, on the falling edge. The slot count is registered. The effect of an issue or advance strobe therefore appears one rising edge later, and the bench reads slotsUsed on the falling edge that follows that rising edge. Every vector sets up its inputs, checks hazard before the edge, and checks slotsUsed after it.

// File: rtl/dgrp_pkg.sv
package dgrp_pkg;
  localparam int GROUP_SLOTS = 5;
  localparam int SLOT_W = $clog2(GROUP_SLOTS + 1);
  localparam int CR_SLOTS = 2;
  localparam int CRACK_LIMIT = 2;

  typedef enum logic [2:0] {
    U_FXU = 3'd0, U_LSU = 3'd1, U_FPU = 3'd2, U_VALU = 3'd3,
    U_VPERM = 3'd4, U_CRU = 3'd5, U_BRU = 3'd6
  } unit_e;

  typedef enum logic [1:0] {
    HZ_NONE = 2'b00, HZ_WAIT = 2'b01, HZ_NOOP = 2'b10
  } hazard_e;

  typedef struct packed {
    logic doIssue;
    logic doAdvance;
    logic closeGroup;
    logic twoSlots;
    logic setCtr;
  } ctrl_s;
endpackage

// File: rtl/dgrp_ctrl.sv
module dgrp_ctrl
  import dgrp_pkg::*;
(
  input  logic [2:0]        unitClass,
  input  logic              isFirst,
  input  logic              isSingle,
  input  logic              isCracked,
  input  logic              isCtrWrite,
  input  logic              isCtrBranch,
  input  logic              isPseudo,
  input  logic              issueStb,
  input  logic              advanceStb,
  input  logic [SLOT_W-1:0] slotCnt,
  input  logic              ctrSet,
  output logic [1:0]        hazard,
  output ctrl_s             ctrl
);
  logic isBranch, isCru, waitHit;

  always_comb begin
    isBranch = (unitClass == U_BRU);
    isCru    = (unitClass == U_CRU);
    waitHit  = 1'b0;
    if ((isFirst || isSingle) && slotCnt != '0) waitHit = 1'b1;
    if (isCracked && slotCnt > SLOT_W'(CRACK_LIMIT)) waitHit = 1'b1;
    if (isCru && slotCnt >= SLOT_W'(CR_SLOTS)) waitHit = 1'b1;
    if (!isBranch && !isCru && slotCnt == SLOT_W'(GROUP_SLOTS - 1)) waitHit = 1'b1;

    if (isPseudo)                 hazard = HZ_NONE;
    else if (waitHit)             hazard = HZ_WAIT;
    else if (ctrSet && isCtrBranch) hazard = HZ_NOOP;
    else                          hazard = HZ_NONE;

    ctrl.doIssue    = issueStb && !isPseudo;
    ctrl.doAdvance  = advanceStb && !issueStb;
    ctrl.closeGroup = isBranch || isSingle;
    ctrl.twoSlots   = isCracked;
    ctrl.setCtr     = isCtrWrite;
  end
endmodule

// File: rtl/dgrp_state.sv
module dgrp_state
  import dgrp_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  ctrl_s             ctrl,
  output logic [SLOT_W-1:0] slotCnt,
  output logic              ctrSet
);
  logic [SLOT_W:0] nextCnt;
  logic            nextCtr;

  always_comb begin
    nextCnt = {1'b0, slotCnt};
    nextCtr = ctrSet;
    if (ctrl.doIssue) begin
      if (ctrl.setCtr) nextCtr = 1'b1;
      if (ctrl.closeGroup) nextCnt = (SLOT_W+1)'(GROUP_SLOTS - 1);
      nextCnt = nextCnt + 1'b1 + {{SLOT_W{1'b0}}, ctrl.twoSlots};
    end else if (ctrl.doAdvance) begin
      nextCnt = nextCnt + 1'b1;
    end
    if (nextCnt >= (SLOT_W+1)'(GROUP_SLOTS)) begin
      nextCnt = '0;
      nextCtr = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      slotCnt <= '0;
      ctrSet  <= 1'b0;
    end else begin
      slotCnt <= nextCnt[SLOT_W-1:0];
      ctrSet  <= nextCtr;
    end
  end

  p_slot_bound_r10: assert property (@(posedge clk) disable iff (rst)
    slotCnt < SLOT_W'(GROUP_SLOTS));
  p_adv_legal_r10: assert property (@(posedge clk) disable iff (rst)
    ctrl.doAdvance |-> slotCnt < SLOT_W'(GROUP_SLOTS));
  p_hold_r11: assert property (@(posedge clk) disable iff (rst)
    (!ctrl.doIssue && !ctrl.doAdvance) |=> $stable(slotCnt) && $stable(ctrSet));
  p_close_r7: assert property (@(posedge clk) disable iff (rst)
    (ctrl.doIssue && ctrl.closeGroup) |=> slotCnt == '0 && !ctrSet);
endmodule

// File: rtl/dgrp_hazard_top.sv
module dgrp_hazard_top
  import dgrp_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [2:0] unitClass,
  input  logic       isFirst,
  input  logic       isSingle,
  input  logic       isCracked,
  input  logic       isCtrWrite,
  input  logic       isCtrBranch,
  input  logic       isPseudo,
  input  logic       issueStb,
  input  logic       advanceStb,
  output logic [1:0] hazard,
  output logic [2:0] slotsUsed
);
  ctrl_s             ctrl;
  logic [SLOT_W-1:0] slotCnt;
  logic              ctrSet;

  dgrp_ctrl u_ctrl (
    .unitClass(unitClass), .isFirst(isFirst), .isSingle(isSingle),
    .isCracked(isCracked), .isCtrWrite(isCtrWrite), .isCtrBranch(isCtrBranch),
    .isPseudo(isPseudo), .issueStb(issueStb), .advanceStb(advanceStb),
    .slotCnt(slotCnt), .ctrSet(ctrSet), .hazard(hazard), .ctrl(ctrl)
  );

  dgrp_state u_state (
    .clk(clk), .rst(rst), .ctrl(ctrl), .slotCnt(slotCnt), .ctrSet(ctrSet)
  );

  assign slotsUsed = 3'(slotCnt);

  p_pseudo_r9: assert property (@(posedge clk) disable iff (rst)
    isPseudo |-> hazard == HZ_NONE);
  p_pseudo_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (isPseudo && !advanceStb) |=> $stable(slotsUsed));
  p_first_r4: assert property (@(posedge clk) disable iff (rst)
    (!isPseudo && (isFirst || isSingle) && slotsUsed != 3'd0) |-> hazard == HZ_WAIT);
  p_cru_r6: assert property (@(posedge clk) disable iff (rst)
    (!isPseudo && unitClass == U_CRU && slotsUsed >= 3'd2) |-> hazard == HZ_WAIT);
  p_enc_r2: assert property (@(posedge clk) disable iff (rst)
    hazard != 2'b11);
endmodule

// File: tb/test_dgrp_hazard_top.sv
module test_dgrp_hazard_top;
  localparam int CLK_PERIOD = 10;
  // vector: unit,first,single,crack,ctrw,ctrb,pseudo,issue,adv, expHaz, expSlotsAfter
  localparam int NV = 24;
  localparam logic [17:0] VEC [NV] = '{
    {3'd0,7'b0000000,2'b10,2'b00,3'd1, 1'b0}, // R3 fxu issue ->1
    {3'd5,7'b0000000,2'b10,2'b00,3'd2, 1'b0}, // R6 cru at 1 ok ->2
    {3'd5,7'b0000000,2'b00,2'b01,3'd2, 1'b0}, // R6 cru at 2 hazard, R11 hold
    {3'd0,7'b1000000,2'b00,2'b01,3'd2, 1'b0}, // R4 first at 2
    {3'd1,7'b0010000,2'b10,2'b00,3'd4, 1'b0}, // R5 cracked at 2 ok ->4
    {3'd2,7'b0000000,2'b00,2'b01,3'd4, 1'b0}, // R3 fpu at 4
    {3'd4,7'b0000000,2'b00,2'b01,3'd4, 1'b0}, // R3 vperm at 4
    {3'd6,7'b0000000,2'b10,2'b00,3'd0, 1'b0}, // R3 branch at 4 ok, ends group
    {3'd0,7'b0100000,2'b10,2'b00,3'd0, 1'b0}, // R7 single at 0 closes
    {3'd0,7'b0000010,2'b10,2'b00,3'd0, 1'b0}, // R9 pseudo no slot
    {3'd0,7'b0001000,2'b10,2'b00,3'd1, 1'b0}, // R8 ctr write ->1
    {3'd6,7'b0000100,2'b00,2'b10,3'd1, 1'b0}, // R8 noop hazard
    {3'd0,7'b0000000,2'b01,2'b00,3'd2, 1'b0}, // R10 advance ->2
    {3'd1,7'b0010000,2'b10,2'b00,3'd4, 1'b0}, // R5 crack ->4
    {3'd6,7'b0000100,2'b10,2'b10,3'd0, 1'b0}, // R8 noop + close
    {3'd6,7'b0000100,2'b00,2'b00,3'd0, 1'b0}, // R8 flag cleared
    {3'd0,7'b0000000,2'b01,2'b00,3'd1, 1'b0}, // R10
    {3'd0,7'b0000000,2'b01,2'b00,3'd2, 1'b0}, // R10
    {3'd0,7'b0000000,2'b01,2'b00,3'd3, 1'b0}, // R10
    {3'd3,7'b0010000,2'b00,2'b01,3'd3, 1'b0}, // R5 crack at 3 hazard
    {3'd0,7'b0000000,2'b01,2'b00,3'd4, 1'b0}, // R10 ->4
    {3'd0,7'b0000000,2'b01,2'b01,3'd0, 1'b0}, // R10 advance at 4 ends group
    {3'd0,7'b0000010,2'b10,2'b00,3'd0, 1'b0}, // R9
    {3'd0,7'b0000000,2'b00,2'b00,3'd0, 1'b0}  // R1 empty
  };

  logic clk = 0, rst = 1;
  logic [2:0] unitClass = 0;
  logic isFirst = 0, isSingle = 0, isCracked = 0, isCtrWrite = 0, isCtrBranch = 0, isPseudo = 0;
  logic issueStb = 0, advanceStb = 0;
  logic [1:0] hazard;
  logic [2:0] slotsUsed;
  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dgrp_hazard_top i_dgrp_hazard_top (.*);

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  initial begin
    #(CLK_PERIOD*5000);
    errors++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 0;
    chk("R1 slots", slotsUsed, 0);
    chk("R1 hazard", hazard, 0);
    for (int i = 0; i < NV; i++) begin
      logic [17:0] v;
      v = VEC[i];
      unitClass = v[17:15];
      {isFirst, isSingle, isCracked, isCtrWrite, isCtrBranch, isPseudo} = v[14:9];
      {issueStb, advanceStb} = v[7:6];
      #1;
      chk($sformatf("R2 vec%0d hazard", i), hazard, int'(v[5:4]));
      @(negedge clk);
      chk($sformatf("R11 vec%0d slots", i), slotsUsed, int'(v[3:1]));
    end
    issueStb = 0; advanceStb = 0;
    // R8: hazard outranks noop when ctr flag set at slot 4
    unitClass = 0; isCtrWrite = 1; issueStb = 1; @(negedge clk);
    isCtrWrite = 0; issueStb = 0; advanceStb = 1;
    repeat (3) @(negedge clk);
    advanceStb = 0; isCtrBranch = 1; unitClass = 0; #1;
    chk("R8 precedence", hazard, 1);
    isCtrBranch = 0;
    // R1 reset mid-group
    rst = 1; @(negedge clk); rst = 0;
    chk("R1 reset clears", slotsUsed, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule